// File: doc/BRIEF.md
# Rename Move Elimination Arbiter

This block sits in the rename stage of an out-of-order core. In each clock cycle it receives up to `LANES` register-to-register move candidates, in program order. For each one it decides whether the move can be removed at rename. A removed move makes its destination an alias of the source and takes no new physical register. For every lane the block reports an accept flag, the alias register chosen, and a zero flag. The zero flag marks both the eliminated write and its read as carrying a known-zero value. Physical register allocation is handled elsewhere.

A small alias table, with one entry per architectural register id, records which register each id currently aliases. An entry of zero means the id has no alias. The table is updated at the clock edge. Within a cycle, each lane sees the updates made by the lanes before it. An ordinary, non-eliminated write, presented on a separate port, clears the alias entries it overwrites. Each register bank has a per-cycle cap on eliminations and an optional mode that eliminates only moves of known-zero values.

Register ids follow a fixed pairing. An even id `r` is a wide register whose only sub-register is `r+1`. An odd id has no sub-register. Id 0 is never used as a register, so an alias value of 0 means "no alias". A rename-as value of 0 means the register is its own rename target.

Top module: `mve_elim_arbiter`

## Requirements
- R1: A valid candidate whose source bank differs from its destination bank is rejected (`e_accept` low).
- R2: When the destination's rename-as id is nonzero and differs from the destination id, the candidate is rejected unless both `c_wide_ok` and `c_clr_up` are high for that lane. A rename-as id equal to the destination imposes no condition.
- R3: Each bank `b` has a limit in `cfg_limit[b*LIMIT_W +: LIMIT_W]`. A candidate is rejected when the number of earlier accepted lanes in the same cycle whose destination is in its bank equals that limit. A limit of 0 means no limit. Lanes in another bank do not count.
- R4: The per-bank elimination counts start from zero in every clock cycle, so accepts from one cycle never limit the next.
- R5: When `cfg_zero_only[b]` is high, a candidate with destination bank `b` and `c_src_zero` low is rejected.
- R6: The lookup key is the source rename-as id if that id is nonzero, and the source id otherwise. `e_alias` is the key's alias-table entry if that entry is nonzero, and the key itself otherwise. Only one level of alias is followed.
- R7: When a lane is accepted and its `e_alias` differs from its destination, the table entries of the destination and of its sub-register (destination+1 when the destination is even) take that alias. Later lanes in the same cycle see the change, and `q_alias` shows it from the next cycle.
- R8: `e_zero` of a lane is high exactly when the lane is accepted and its `c_src_zero` is high.
- R9: An ordinary write (`pw_valid`, `pw_id`) clears the table entry of `pw_id` and, when `pw_id` is even, of `pw_id+1`. The clear is applied before any same-cycle move, so moves in that cycle see the cleared entries and can overwrite them.
- R10: Reset sets every alias table entry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_limit | input | NUM_BANKS*LIMIT_W | Per-bank elimination cap per cycle, 0 = unlimited |
| cfg_zero_only | input | NUM_BANKS | Per-bank known-zero-only mode |
| c_valid | input | LANES | Candidate present, lane 0 oldest |
| c_src | input | LANES*RW | Source register id per lane |
| c_dst | input | LANES*RW | Destination register id per lane |
| c_src_bank | input | LANES*BW | Bank owning the source |
| c_dst_bank | input | LANES*BW | Bank owning the destination |
| c_src_ren | input | LANES*RW | Source rename-as id, 0 = itself |
| c_dst_ren | input | LANES*RW | Destination rename-as id, 0 = itself |
| c_wide_ok | input | LANES | The destination's wider rename target permits elimination |
| c_clr_up | input | LANES | The write clears the upper part of the wider register |
| c_src_zero | input | LANES | Source value is known to be zero |
| pw_valid | input | 1 | Ordinary write present this cycle |
| pw_id | input | RW | Register id of the ordinary write |
| q_id | input | RW | Alias table lookup id |
| q_alias | output | RW | Registered alias entry of `q_id` |
| e_accept | output | LANES | Move eliminated |
| e_zero | output | LANES | Eliminated write and its read are known zero |
| e_alias | output | LANES*RW | Alias register chosen for the lane |

## Verification
The hardest situation to reach is one where several ordering effects meet in a single cycle. An ordinary write clears an entry, a lane reads that same entry, and a later lane reads an alias that an earlier lane created in that cycle. Two lanes of one bank meeting its cap while a lane of another bank goes through is another such case. The stimulus stages every lane and the write port separately and applies them together. It chains destinations into later sources, and it reuses the same registers across cycles so that one-level alias following, sub-register propagation and clearing all act on entries that earlier cycles left behind.

// File: rtl/mve_pkg.sv
package mve_pkg;

    // Why a lane was or was not allowed to eliminate its move.
    typedef enum logic [2:0] {
        VERDICT_IDLE,
        VERDICT_TAKE,
        VERDICT_BANK,
        VERDICT_WIDE,
        VERDICT_LIMIT,
        VERDICT_ZERO
    } verdict_e;

    // True when register 'r' is 'owner' itself or owner's sub-register.
    // Even ids are wide registers owning the next odd id.
    function automatic bit covers(int owner, int r);
        return (r == owner) || ((owner % 2 == 0) && (r == owner + 1));
    endfunction

endpackage

// File: rtl/mve_lane.sv
module mve_lane
    import mve_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int LIMIT_W   = 3,
    localparam int RW = $clog2(NUM_REGS),
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          valid,
    input  logic [RW-1:0]                 src,
    input  logic [RW-1:0]                 dst,
    input  logic [BW-1:0]                 src_bank,
    input  logic [BW-1:0]                 dst_bank,
    input  logic [RW-1:0]                 src_ren,
    input  logic [RW-1:0]                 dst_ren,
    input  logic                          wide_ok,
    input  logic                          clr_up,
    input  logic                          src_zero,
    input  logic [NUM_BANKS*LIMIT_W-1:0]  cfg_limit,
    input  logic [NUM_BANKS-1:0]          cfg_zero_only,
    input  logic [NUM_BANKS*LIMIT_W-1:0]  cnt_in,
    input  logic [NUM_REGS*RW-1:0]        view_in,
    output logic                          accept,
    output logic                          zero,
    output logic [RW-1:0]                 alias_o,
    output logic [NUM_BANKS*LIMIT_W-1:0]  cnt_out,
    output logic [NUM_REGS*RW-1:0]        view_out
);

    logic [LIMIT_W-1:0] used;
    logic [LIMIT_W-1:0] cap;
    logic               zonly;
    logic [RW-1:0]      key;
    logic [RW-1:0]      prior;
    logic               renamed_wide;
    verdict_e           verdict;

    // Per-bank configuration and running count for the destination bank.
    always_comb begin
        used  = '0;
        cap   = '0;
        zonly = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (BW'(b) == dst_bank) begin
                used  = cnt_in[b*LIMIT_W +: LIMIT_W];
                cap   = cfg_limit[b*LIMIT_W +: LIMIT_W];
                zonly = cfg_zero_only[b];
            end
        end
    end

    // Alias lookup: key is the source's rename target, one level followed.
    assign key = (src_ren != '0) ? src_ren : src;

    always_comb begin
        prior = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (RW'(r) == key) prior = view_in[r*RW +: RW];
        end
    end

    assign alias_o      = (prior != '0) ? prior : key;
    assign renamed_wide = (dst_ren != '0) && (dst_ren != dst);

    // Rule chain, first failing rule names the verdict.
    always_comb begin
        if (!valid)                              verdict = VERDICT_IDLE;
        else if (src_bank != dst_bank)           verdict = VERDICT_BANK;
        else if (renamed_wide && !(wide_ok && clr_up))
                                                 verdict = VERDICT_WIDE;
        else if ((cap != '0) && (used == cap))   verdict = VERDICT_LIMIT;
        else if (zonly && !src_zero)             verdict = VERDICT_ZERO;
        else                                     verdict = VERDICT_TAKE;
    end

    always_comb begin
        unique case (verdict)
            VERDICT_TAKE:  accept = 1'b1;
            VERDICT_IDLE,
            VERDICT_BANK,
            VERDICT_WIDE,
            VERDICT_LIMIT,
            VERDICT_ZERO:  accept = 1'b0;
            default:       accept = 1'b0;
        endcase
    end

    assign zero = accept && src_zero;

    // Hand the updated per-bank counts to the next lane.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            cnt_out[b*LIMIT_W +: LIMIT_W] = cnt_in[b*LIMIT_W +: LIMIT_W]
                + LIMIT_W'(accept && (BW'(b) == dst_bank));
        end
    end

    // Hand the updated alias view to the next lane.
    always_comb begin
        view_out = view_in;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (accept && (alias_o != dst) && covers(int'(dst), r)) begin
                view_out[r*RW +: RW] = alias_o;
            end
        end
    end

endmodule

// File: rtl/mve_alias_store.sv
module mve_alias_store
    import mve_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int RW = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pw_valid,
    input  logic [RW-1:0]          pw_id,
    input  logic [NUM_REGS*RW-1:0] nxt_view,
    input  logic [RW-1:0]          q_id,
    output logic [RW-1:0]          q_alias,
    output logic [NUM_REGS*RW-1:0] cur_view,
    output logic [NUM_REGS*RW-1:0] base_view
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_view <= '0;
        else        cur_view <= nxt_view;
    end

    // Ordinary writes are older than any move in the same cycle.
    always_comb begin
        base_view = cur_view;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (pw_valid && covers(int'(pw_id), r)) base_view[r*RW +: RW] = '0;
        end
    end

    always_comb begin
        q_alias = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (RW'(r) == q_id) q_alias = cur_view[r*RW +: RW];
        end
    end

endmodule

// File: rtl/mve_elim_arbiter.sv
module mve_elim_arbiter
    import mve_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int LANES     = 2,
    parameter int LIMIT_W   = 3,
    localparam int RW = $clog2(NUM_REGS),
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANKS*LIMIT_W-1:0] cfg_limit,
    input  logic [NUM_BANKS-1:0]         cfg_zero_only,
    input  logic [LANES-1:0]             c_valid,
    input  logic [LANES*RW-1:0]          c_src,
    input  logic [LANES*RW-1:0]          c_dst,
    input  logic [LANES*BW-1:0]          c_src_bank,
    input  logic [LANES*BW-1:0]          c_dst_bank,
    input  logic [LANES*RW-1:0]          c_src_ren,
    input  logic [LANES*RW-1:0]          c_dst_ren,
    input  logic [LANES-1:0]             c_wide_ok,
    input  logic [LANES-1:0]             c_clr_up,
    input  logic [LANES-1:0]             c_src_zero,
    input  logic                         pw_valid,
    input  logic [RW-1:0]                pw_id,
    input  logic [RW-1:0]                q_id,
    output logic [RW-1:0]                q_alias,
    output logic [LANES-1:0]             e_accept,
    output logic [LANES-1:0]             e_zero,
    output logic [LANES*RW-1:0]          e_alias
);

    logic [LANES:0][NUM_REGS*RW-1:0]        view_chain;
    logic [LANES:0][NUM_BANKS*LIMIT_W-1:0]  cnt_chain;
    logic [NUM_REGS*RW-1:0]                 table_cur;

    assign cnt_chain[0] = '0;   // counts restart every cycle

    mve_alias_store #(
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .pw_valid  (pw_valid),
        .pw_id     (pw_id),
        .nxt_view  (view_chain[LANES]),
        .q_id      (q_id),
        .q_alias   (q_alias),
        .cur_view  (table_cur),
        .base_view (view_chain[0])
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        mve_lane #(
            .NUM_REGS  (NUM_REGS),
            .NUM_BANKS (NUM_BANKS),
            .LIMIT_W   (LIMIT_W)
        ) u_lane (
            .valid         (c_valid[i]),
            .src           (c_src[i*RW +: RW]),
            .dst           (c_dst[i*RW +: RW]),
            .src_bank      (c_src_bank[i*BW +: BW]),
            .dst_bank      (c_dst_bank[i*BW +: BW]),
            .src_ren       (c_src_ren[i*RW +: RW]),
            .dst_ren       (c_dst_ren[i*RW +: RW]),
            .wide_ok       (c_wide_ok[i]),
            .clr_up        (c_clr_up[i]),
            .src_zero      (c_src_zero[i]),
            .cfg_limit     (cfg_limit),
            .cfg_zero_only (cfg_zero_only),
            .cnt_in        (cnt_chain[i]),
            .view_in       (view_chain[i]),
            .accept        (e_accept[i]),
            .zero          (e_zero[i]),
            .alias_o       (e_alias[i*RW +: RW]),
            .cnt_out       (cnt_chain[i+1]),
            .view_out      (view_chain[i+1])
        );
    end

endmodule

// File: rtl/mve_checker.sv
module mve_checker #(
    parameter int NUM_REGS  = 16,
    parameter int NUM_BANKS = 2,
    parameter int LANES     = 2,
    parameter int LIMIT_W   = 3,
    localparam int RW = $clog2(NUM_REGS),
    localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANKS*LIMIT_W-1:0] cfg_limit,
    input  logic [NUM_BANKS-1:0]         cfg_zero_only,
    input  logic [LANES*RW-1:0]          c_dst,
    input  logic [LANES*BW-1:0]          c_src_bank,
    input  logic [LANES*BW-1:0]          c_dst_bank,
    input  logic [LANES*RW-1:0]          c_dst_ren,
    input  logic [LANES-1:0]             c_wide_ok,
    input  logic [LANES-1:0]             c_clr_up,
    input  logic [LANES-1:0]             c_src_zero,
    input  logic                         pw_valid,
    input  logic [RW-1:0]                pw_id,
    input  logic [LANES-1:0]             e_accept,
    input  logic [LANES-1:0]             e_zero,
    input  logic [LANES*RW-1:0]          e_alias,
    input  logic [NUM_REGS*RW-1:0]       table_cur
);

    logic [LIMIT_W:0] taken [NUM_BANKS];

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            taken[b] = '0;
            for (int i = 0; i < LANES; i++) begin
                if (e_accept[i] && (c_dst_bank[i*BW +: BW] == BW'(b))) taken[b] = taken[b] + 1'b1;
            end
        end
    end

    // Remember last cycle's final alias write and ordinary write.
    logic          wr_seen, clr_seen;
    logic [RW-1:0] wr_dst, wr_alias, clr_id;
    logic [RW-1:0] ent_wr, ent_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen  <= 1'b0;
            clr_seen <= 1'b0;
            wr_dst   <= '0;
            wr_alias <= '0;
            clr_id   <= '0;
        end else begin
            wr_seen  <= e_accept[LANES-1]
                        && (e_alias[(LANES-1)*RW +: RW] != c_dst[(LANES-1)*RW +: RW]);
            wr_dst   <= c_dst[(LANES-1)*RW +: RW];
            wr_alias <= e_alias[(LANES-1)*RW +: RW];
            clr_seen <= pw_valid && (e_accept == '0);
            clr_id   <= pw_id;
        end
    end

    always_comb begin
        ent_wr  = '0;
        ent_clr = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (RW'(r) == wr_dst) ent_wr  = table_cur[r*RW +: RW];
            if (RW'(r) == clr_id) ent_clr = table_cur[r*RW +: RW];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        assert_bank_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
            e_accept[i] |-> (c_src_bank[i*BW +: BW] == c_dst_bank[i*BW +: BW]));

        assert_wide_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (e_accept[i] && (c_dst_ren[i*RW +: RW] != '0)
                && (c_dst_ren[i*RW +: RW] != c_dst[i*RW +: RW]))
            |-> (c_wide_ok[i] && c_clr_up[i]));

        assert_zero_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (e_accept[i] && cfg_zero_only[c_dst_bank[i*BW +: BW]]) |-> c_src_zero[i]);

        assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            e_zero[i] |-> (e_accept[i] && c_src_zero[i]));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        assert_bank_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_limit[b*LIMIT_W +: LIMIT_W] != '0)
            |-> (taken[b] <= {1'b0, cfg_limit[b*LIMIT_W +: LIMIT_W]}));
    end

    assert_alias_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |-> (ent_wr == wr_alias));

    assert_plain_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_seen |-> (ent_clr == '0));

endmodule

bind mve_elim_arbiter mve_checker #(
    .NUM_REGS  (NUM_REGS),
    .NUM_BANKS (NUM_BANKS),
    .LANES     (LANES),
    .LIMIT_W   (LIMIT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_limit     (cfg_limit),
    .cfg_zero_only (cfg_zero_only),
    .c_dst         (c_dst),
    .c_src_bank    (c_src_bank),
    .c_dst_bank    (c_dst_bank),
    .c_dst_ren     (c_dst_ren),
    .c_wide_ok     (c_wide_ok),
    .c_clr_up      (c_clr_up),
    .c_src_zero    (c_src_zero),
    .pw_valid      (pw_valid),
    .pw_id         (pw_id),
    .e_accept      (e_accept),
    .e_zero        (e_zero),
    .e_alias       (e_alias),
    .table_cur     (table_cur)
);

// File: tb/sim_mve_elim_arbiter.sv
module sim_mve_elim_arbiter;

    localparam int NR = 16;
    localparam int NB = 2;
    localparam int NL = 2;
    localparam int LW = 3;
    localparam int RW = 4;
    localparam int BW = 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NB*LW-1:0]    cfg_limit = '0;
    logic [NB-1:0]       cfg_zero_only = '0;
    logic [NL-1:0]       c_valid = '0;
    logic [NL*RW-1:0]    c_src = '0, c_dst = '0, c_src_ren = '0, c_dst_ren = '0;
    logic [NL*BW-1:0]    c_src_bank = '0, c_dst_bank = '0;
    logic [NL-1:0]       c_wide_ok = '0, c_clr_up = '0, c_src_zero = '0;
    logic                pw_valid = 1'b0;
    logic [RW-1:0]       pw_id = '0;
    logic [RW-1:0]       q_id = '0;
    logic [RW-1:0]       q_alias;
    logic [NL-1:0]       e_accept, e_zero;
    logic [NL*RW-1:0]    e_alias;

    always #5 clk = ~clk;

    mve_elim_arbiter #(.NUM_REGS(NR), .NUM_BANKS(NB), .LANES(NL), .LIMIT_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .cfg_zero_only(cfg_zero_only),
        .c_valid(c_valid), .c_src(c_src), .c_dst(c_dst), .c_src_bank(c_src_bank),
        .c_dst_bank(c_dst_bank), .c_src_ren(c_src_ren), .c_dst_ren(c_dst_ren),
        .c_wide_ok(c_wide_ok), .c_clr_up(c_clr_up), .c_src_zero(c_src_zero),
        .pw_valid(pw_valid), .pw_id(pw_id), .q_id(q_id), .q_alias(q_alias),
        .e_accept(e_accept), .e_zero(e_zero), .e_alias(e_alias)
    );

    // Staged stimulus and bench-side reference state.
    int  s_src[NL], s_dst[NL], s_sb[NL], s_db[NL], s_sren[NL], s_dren[NL];
    bit  s_val[NL], s_wok[NL], s_clr[NL], s_sz[NL];
    int  s_q = 0;
    bit  s_pw_v = 0;
    int  s_pw = 0;
    int  limit[NB];
    bit  zonly[NB];
    int  mt[NR];

    typedef struct {
        string name;
        bit    acc[NL];
        bit    zer[NL];
        int    ali[NL];
        int    qal;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;

    task automatic chk(bit ok, string name, string field, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", name, field, act, expv);
        end
    endtask

    task automatic clr_all();
        for (int i = 0; i < NL; i++) begin
            s_val[i] = 0; s_src[i] = 0; s_dst[i] = 0; s_sb[i] = 0; s_db[i] = 0;
            s_sren[i] = 0; s_dren[i] = 0; s_wok[i] = 0; s_clr[i] = 0; s_sz[i] = 0;
        end
        s_pw_v = 0;
    endtask

    task automatic cand(int i, int src, int dst, int bank, int sren = 0, int dren = 0,
                        bit wok = 0, bit clr = 0, bit sz = 0);
        s_val[i] = 1; s_src[i] = src; s_dst[i] = dst; s_sb[i] = bank; s_db[i] = bank;
        s_sren[i] = sren; s_dren[i] = dren; s_wok[i] = wok; s_clr[i] = clr; s_sz[i] = sz;
    endtask

    // Driver: applies the staged cycle and pushes the expected results.
    task automatic go(string name);
        exp_t e;
        int   cnt[NB];
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            cfg_limit[b*LW +: LW] = LW'(limit[b]);
            cfg_zero_only[b] = zonly[b];
            cnt[b] = 0;
        end
        for (int i = 0; i < NL; i++) begin
            c_valid[i] = s_val[i];
            c_src[i*RW +: RW] = RW'(s_src[i]);
            c_dst[i*RW +: RW] = RW'(s_dst[i]);
            c_src_bank[i*BW +: BW] = BW'(s_sb[i]);
            c_dst_bank[i*BW +: BW] = BW'(s_db[i]);
            c_src_ren[i*RW +: RW] = RW'(s_sren[i]);
            c_dst_ren[i*RW +: RW] = RW'(s_dren[i]);
            c_wide_ok[i] = s_wok[i];
            c_clr_up[i] = s_clr[i];
            c_src_zero[i] = s_sz[i];
        end
        pw_valid = s_pw_v;
        pw_id = RW'(s_pw);
        q_id = RW'(s_q);
        e.name = name;
        e.qal = mt[s_q];
        if (s_pw_v) begin
            mt[s_pw] = 0;
            if (s_pw % 2 == 0) mt[s_pw + 1] = 0;
        end
        for (int i = 0; i < NL; i++) begin
            bit ok;
            int key;
            int al;
            ok = s_val[i];
            if (s_sb[i] != s_db[i]) ok = 0;
            if (s_dren[i] != 0 && s_dren[i] != s_dst[i] && !(s_wok[i] && s_clr[i])) ok = 0;
            if (limit[s_db[i]] != 0 && cnt[s_db[i]] == limit[s_db[i]]) ok = 0;
            if (zonly[s_db[i]] && !s_sz[i]) ok = 0;
            key = (s_sren[i] != 0) ? s_sren[i] : s_src[i];
            al = (mt[key] != 0) ? mt[key] : key;
            e.acc[i] = ok;
            e.zer[i] = ok && s_sz[i];
            e.ali[i] = al;
            if (ok) begin
                cnt[s_db[i]]++;
                if (al != s_dst[i]) begin
                    mt[s_dst[i]] = al;
                    if (s_dst[i] % 2 == 0) mt[s_dst[i] + 1] = al;
                end
            end
        end
        sbq.push_back(e);
    endtask

    // Monitor: compares mid-cycle, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(q_alias == RW'(e.qal), e.name, "q_alias", int'(q_alias), e.qal);
                for (int i = 0; i < NL; i++) begin
                    chk(e_accept[i] == e.acc[i], e.name, $sformatf("e_accept[%0d]", i),
                        int'(e_accept[i]), int'(e.acc[i]));
                    chk(e_zero[i] == e.zer[i], e.name, $sformatf("e_zero[%0d]", i),
                        int'(e_zero[i]), int'(e.zer[i]));
                    if (e.acc[i])
                        chk(e_alias[i*RW +: RW] == RW'(e.ali[i]), e.name,
                            $sformatf("e_alias[%0d]", i), int'(e_alias[i*RW +: RW]), e.ali[i]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) mt[r] = 0;
        limit[0] = 1; limit[1] = 0;
        zonly[0] = 0; zonly[1] = 0;
        clr_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        s_q = 6; go("R10 table empty after reset");
        s_q = 7; go("R10 sub entry empty after reset");

        cand(0, 4, 6, 0); s_db[0] = 1;
        cand(1, 2, 8, 1); s_sb[1] = 0;
        go("R1 cross-bank moves rejected");

        clr_all(); cand(0, 4, 6, 1); go("R6 plain alias");
        clr_all(); s_q = 6; go("R7 alias stored at destination");
        s_q = 7; go("R7 alias stored at sub-register");

        cand(0, 6, 8, 1); go("R6 alias followed one level");
        clr_all(); s_q = 9; go("R7 followed alias at sub of 8");

        cand(0, 10, 12, 1); cand(1, 12, 14, 1); go("R7 later lane sees earlier alias");
        clr_all(); s_q = 15; go("R7 second lane table update");

        cand(0, 1, 5, 0); cand(1, 3, 9, 0); go("R3 bank cap stops second lane");
        go("R4 count restarts next cycle");
        clr_all(); cand(0, 1, 5, 0); cand(1, 3, 11, 1); go("R3 cap is per bank");
        clr_all(); cand(0, 2, 3, 1); cand(1, 4, 13, 1); go("R3 zero limit unlimited");

        clr_all(); cand(0, 2, 7, 1, 0, 6, 0, 1); go("R2 wide target forbids elimination");
        clr_all(); cand(0, 2, 7, 1, 0, 6, 1, 0); go("R2 upper part not cleared");
        clr_all(); cand(0, 2, 7, 1, 0, 6, 1, 1); go("R2 wide rule satisfied");
        clr_all(); cand(0, 2, 7, 1, 0, 7, 0, 0); go("R2 self rename target");

        zonly[1] = 1;
        clr_all(); cand(0, 2, 3, 1, 0, 0, 0, 0, 0); go("R5 non-zero source in zero-only bank");
        clr_all(); cand(0, 2, 3, 1, 0, 0, 0, 0, 1); go("R5 R8 zero source accepted and flagged");
        clr_all(); cand(0, 2, 5, 0, 0, 0, 0, 0, 0); go("R5 other bank unaffected");
        zonly[1] = 0;
        clr_all(); cand(0, 2, 3, 1, 0, 0, 0, 0, 0); go("R8 non-zero move not flagged");

        clr_all(); s_pw_v = 1; s_pw = 6; go("R9 ordinary write to 6");
        clr_all(); s_q = 6; go("R9 entry 6 cleared");
        s_q = 7; go("R9 sub entry 7 cleared");
        s_pw_v = 1; s_pw = 9; go("R9 ordinary write to odd 9");
        clr_all(); s_q = 8; go("R9 owner 8 kept");
        s_q = 9; go("R9 entry 9 cleared");
        s_pw_v = 1; s_pw = 8; cand(0, 8, 2, 1); go("R9 clear seen by same-cycle move");
        clr_all(); s_pw_v = 1; s_pw = 12; cand(0, 3, 12, 1); go("R9 move overwrites same-cycle clear");
        clr_all(); s_q = 12; go("R9 R7 entry 12 from move");
        s_q = 2; go("R9 entry 2 after cleared-key move");

        clr_all(); cand(0, 4, 6, 1); go("R7 rebuild alias 6");
        clr_all(); cand(0, 6, 4, 1); go("R7 alias equal to destination");
        clr_all(); s_q = 4; go("R7 no self alias written");

        clr_all(); cand(0, 11, 2, 1, 10); go("R6 source rename-as is key");
        clr_all(); cand(0, 11, 2, 1); cand(1, 2, 14, 1); go("R6 R7 key without rename-as");
        clr_all(); s_q = 14; go("R7 final lane entry");

        clr_all(); go("flush");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule